// File: doc/BRIEF.md
# DAC Serial Configuration Register Bank

This block holds the mode settings of a dual-channel (I and Q) DAC datapath and loads them through a small synchronous serial port. A transaction starts when the active-low select goes low. The host first shifts in an instruction byte that carries a read/write flag and a register address. A data byte follows. On a write, the data lands in the addressed register. On a read, the register contents come back on the serial output during the data byte. Every stored field is driven out as a separate decoded control line: bit order, interpolator clock stop, channel power-downs, interpolation ratio, filter type, modulator settings, input number format, latch edge, and the gain and offset codes.

The serial lines are sampled by the system clock, and edges of the serial clock are found by comparing each sample with the one before it. The host can switch the port between sending the most significant bit first and sending the least significant bit first. The new order applies from the next transaction onward. A self-clearing soft reset, written through the port, returns every register to its default value.

Top module: `dac_cfg_regs`

## Requirements
- R1: After reset the outputs show the defaults: MSB-first order, no clock stop, no power-down, ratio code 2'b11 (8x), lowpass filter, modulation code 2'b10, real mode 1, sign inversion 0, two's complement input, rising latch edge, fine gain 8'h00, coarse gain 4'hF, offset 10'h000.
- R2: A transaction is framed by spiCsN low. spiDin is sampled on each rising edge of spiClk. The instruction byte is {rw, addr[6:0]}, where rw=1 means read. A data byte follows. A write updates the register on the system clock edge that detects the 16th rising serial edge. In MSB-first order, bit 7 of each byte is sent first.
- R3: Register 0 bit 6 = 1 selects LSB-first order, in which bit 0 of each byte is sent first for both the instruction and the data. The order in use is captured while spiCsN is high, so a change takes effect from the next transaction.
- R4: Writing a 1 to register 0 bit 5 returns every register to its R1 default. That bit always reads back as 0.
- R5: Register 0 bit 4 drives interpClkStop, bit 3 drives pdI and bit 2 drives pdQ. fullPowerDown is 1 exactly when both pdI and pdQ are 1.
- R6: Register 1 holds: bits 7:6 interpRatio (00=1x, 01=2x, 10=4x, 11=8x), bit 5 firHighpass, bits 4:3 modFreq, bit 2 modReal, bit 1 modSignInv.
- R7: Register 2 bit 7 drives offsetBinary and bit 4 drives latchFalling.
- R8: Register 4 holds the 8-bit fineGain. Register 5 bits 3:0 hold coarseGain.
- R9: offsetCode is {register 6 bits 7:0, register 7 bits 1:0}.
- R10: During a read, spiDout presents the next data bit after each falling serial edge that follows the instruction, in the order in use. The host samples it before the next rising edge.
- R11: Writes to addresses 3 and 8 through 127, and to unused bits, change nothing. Those addresses and bits read back as 0.
- R12: If spiCsN rises before the 16th rising serial edge, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Active-low transaction select |
| spiClk | input | 1 | Serial clock, oversampled by clk |
| spiDin | input | 1 | Serial data in |
| spiDout | output | 1 | Serial read data out |
| lsbFirst | output | 1 | LSB-first order selected |
| interpClkStop | output | 1 | Stop interpolator clock, hold output |
| pdI | output | 1 | I channel power-down |
| pdQ | output | 1 | Q channel power-down |
| fullPowerDown | output | 1 | Both channels down, only the port stays active |
| interpRatio | output | 2 | Interpolation ratio code |
| firHighpass | output | 1 | Last filter stage set to highpass |
| modFreq | output | 2 | Modulation frequency code |
| modReal | output | 1 | Real (not complex) modulation |
| modSignInv | output | 1 | Complex modulation sign inversion |
| offsetBinary | output | 1 | Input data is offset binary |
| latchFalling | output | 1 | Latch input data on the falling edge |
| fineGain | output | 8 | Fine gain code |
| coarseGain | output | 4 | Coarse gain code |
| offsetCode | output | 10 | Offset magnitude code |

## Verification
The hardest case to reach is the change of bit order. The transaction that sets register 0 bit 6 is still shifted MSB-first. Only the transaction after it may use LSB-first order, and a read in that order must return its data reversed on the wire. The stimulus first writes the order bit in MSB-first form. It then performs a write and a read in LSB-first form, and finally uses a soft reset to return to MSB-first. A behavioural model in the bench finds serial edges independently of the design, so it predicts the result of every transaction and the value of spiDout on every clock.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int SRST_BIT  = 5;
  localparam int ORDER_BIT = 6;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cfgWr_t;

  function automatic logic [DATA_W-1:0] regMask(int idx);
    case (idx)
      0: regMask = 8'h5C;
      1: regMask = 8'hFE;
      2: regMask = 8'h90;
      4: regMask = 8'hFF;
      5: regMask = 8'h0F;
      6: regMask = 8'hFF;
      7: regMask = 8'h03;
      default: regMask = 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regDefault(int idx);
    case (idx)
      1: regDefault = 8'hD4;
      5: regDefault = 8'h0F;
      default: regDefault = 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bitRev(logic [DATA_W-1:0] v);
    for (int i = 0; i < DATA_W; i++) bitRev[i] = v[DATA_W-1-i];
  endfunction
endpackage

// File: rtl/dac_cfg_serial.sv
module dac_cfg_serial
  import dac_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output cfgWr_t            wrBus,
  output logic              sdo
);
  localparam int FRAME = 2 * DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic              sclkQ, lsbTx;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shReg, instr, rdBuf, byteNow, byteVal;
  logic [IDX_W-1:0]  bitIdx;
  logic              sRise, sFall;

  assign sRise   = sclk & ~sclkQ;
  assign sFall   = ~sclk & sclkQ;
  assign byteNow = {shReg[DATA_W-2:0], sdi};
  assign byteVal = lsbTx ? bitRev(byteNow) : byteNow;
  assign rdAddr  = byteVal[ADDR_W-1:0];
  assign bitIdx  = IDX_W'(bitCnt - CNT_W'(DATA_W));

  always_comb begin
    wrBus.wrStb = !csN && sRise && (bitCnt == CNT_W'(FRAME - 1)) && !instr[DATA_W-1];
    wrBus.addr  = instr[ADDR_W-1:0];
    wrBus.data  = byteVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      lsbTx  <= 1'b0;
      bitCnt <= '0;
      shReg  <= '0;
      instr  <= '0;
      rdBuf  <= '0;
      sdo    <= 1'b0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        lsbTx  <= lsbFirst;
        bitCnt <= '0;
        instr  <= '0;
        sdo    <= 1'b0;
      end else if (sRise && bitCnt < CNT_W'(FRAME)) begin
        shReg  <= byteNow;
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(DATA_W - 1)) begin
          instr <= byteVal;
          rdBuf <= rdData;
        end
      end else if (sFall && instr[DATA_W-1] && bitCnt >= CNT_W'(DATA_W)
                   && bitCnt < CNT_W'(FRAME)) begin
        sdo <= lsbTx ? rdBuf[bitIdx] : rdBuf[TOP_IDX - bitIdx];
      end
    end
  end
endmodule

// File: rtl/dac_cfg_bank.sv
module dac_cfg_bank
  import dac_cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgWr_t                     wrBus,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);
  localparam int RIDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic softRst;

  assign softRst = wrBus.wrStb && (wrBus.addr == '0) && wrBus.data[SRST_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[g] <= regDefault(g);
      else if (softRst)
        regQ[g] <= regDefault(g);
      else if (wrBus.wrStb && wrBus.addr == ADDR_W'(g))
        regQ[g] <= wrBus.data & regMask(g);
    end
    assign regFlat[g*DATA_W +: DATA_W] = regQ[g];
  end

  assign rdData = (rdAddr < ADDR_W'(NUM_REGS)) ? regQ[rdAddr[RIDX_W-1:0]] : '0;
endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiCsN,
  input  logic       spiClk,
  input  logic       spiDin,
  output logic       spiDout,
  output logic       lsbFirst,
  output logic       interpClkStop,
  output logic       pdI,
  output logic       pdQ,
  output logic       fullPowerDown,
  output logic [1:0] interpRatio,
  output logic       firHighpass,
  output logic [1:0] modFreq,
  output logic       modReal,
  output logic       modSignInv,
  output logic       offsetBinary,
  output logic       latchFalling,
  output logic [7:0] fineGain,
  output logic [3:0] coarseGain,
  output logic [9:0] offsetCode
);
  cfgWr_t                     wrBus;
  logic [ADDR_W-1:0]          rdAddr;
  logic [DATA_W-1:0]          rdData;
  logic [NUM_REGS*DATA_W-1:0] regFlat;

  dac_cfg_serial u_serial (
    .clk(clk), .rstN(rstN), .csN(spiCsN), .sclk(spiClk), .sdi(spiDin),
    .lsbFirst(lsbFirst), .rdData(rdData), .rdAddr(rdAddr),
    .wrBus(wrBus), .sdo(spiDout)
  );

  dac_cfg_bank u_bank (
    .clk(clk), .rstN(rstN), .wrBus(wrBus), .rdAddr(rdAddr),
    .rdData(rdData), .regFlat(regFlat)
  );

  assign lsbFirst      = regFlat[0*8 + ORDER_BIT];
  assign interpClkStop = regFlat[0*8 + 4];
  assign pdI           = regFlat[0*8 + 3];
  assign pdQ           = regFlat[0*8 + 2];
  assign fullPowerDown = pdI & pdQ;
  assign interpRatio   = regFlat[1*8 + 6 +: 2];
  assign firHighpass   = regFlat[1*8 + 5];
  assign modFreq       = regFlat[1*8 + 3 +: 2];
  assign modReal       = regFlat[1*8 + 2];
  assign modSignInv    = regFlat[1*8 + 1];
  assign offsetBinary  = regFlat[2*8 + 7];
  assign latchFalling  = regFlat[2*8 + 4];
  assign fineGain      = regFlat[4*8 +: 8];
  assign coarseGain    = regFlat[5*8 +: 4];
  assign offsetCode    = {regFlat[6*8 +: 8], regFlat[7*8 +: 2]};
endmodule

// File: rtl/dac_cfg_checker.sv
module dac_cfg_checker
  import dac_cfg_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input cfgWr_t                     wrBus,
  input logic [NUM_REGS*DATA_W-1:0] regFlat,
  input logic                       lsbFirst,
  input logic [1:0]                 interpRatio,
  input logic [1:0]                 modFreq,
  input logic                       modReal,
  input logic [7:0]                 fineGain,
  input logic [3:0]                 coarseGain,
  input logic [9:0]                 offsetCode
);
  a_r4_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rstN)
    (wrBus.wrStb && wrBus.addr == '0 && wrBus.data[SRST_BIT]) |=>
      (!lsbFirst && interpRatio == 2'b11 && modFreq == 2'b10 && modReal &&
       fineGain == 8'h00 && coarseGain == 4'hF && offsetCode == 10'h000));

  a_r12_no_write_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !wrBus.wrStb);

  a_r11_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrBus.wrStb && wrBus.addr >= ADDR_W'(NUM_REGS)) |=> $stable(regFlat));

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrBus.wrStb |=> $stable(regFlat));
endmodule

bind dac_cfg_regs dac_cfg_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(spiCsN), .wrBus(wrBus), .regFlat(regFlat),
  .lsbFirst(lsbFirst), .interpRatio(interpRatio), .modFreq(modFreq),
  .modReal(modReal), .fineGain(fineGain), .coarseGain(coarseGain),
  .offsetCode(offsetCode)
);

// File: tb/sim_dac_cfg_regs.sv
module sim_dac_cfg_regs;
  logic clk = 1'b0, rstN = 1'b0;
  logic spiCsN = 1'b1, spiClk = 1'b0, spiDin = 1'b0;
  logic spiDout, lsbFirst, interpClkStop, pdI, pdQ, fullPowerDown;
  logic [1:0] interpRatio, modFreq;
  logic firHighpass, modReal, modSignInv, offsetBinary, latchFalling;
  logic [7:0] fineGain;
  logic [3:0] coarseGain;
  logic [9:0] offsetCode;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_cfg_regs u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiClk(spiClk), .spiDin(spiDin),
    .spiDout(spiDout), .lsbFirst(lsbFirst), .interpClkStop(interpClkStop),
    .pdI(pdI), .pdQ(pdQ), .fullPowerDown(fullPowerDown),
    .interpRatio(interpRatio), .firHighpass(firHighpass), .modFreq(modFreq),
    .modReal(modReal), .modSignInv(modSignInv), .offsetBinary(offsetBinary),
    .latchFalling(latchFalling), .fineGain(fineGain), .coarseGain(coarseGain),
    .offsetCode(offsetCode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] mMask [8] = '{8'h5C, 8'hFE, 8'h90, 8'h00, 8'hFF, 8'h0F, 8'hFF, 8'h03};
  logic [7:0] mDef  [8] = '{8'h00, 8'hD4, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00};
  logic [7:0] expReg [8];
  bit   bitQ [$];
  bit   prevSclk, lsbTx, expSdo;
  logic [7:0] instrV, rdByte;

  function automatic logic [7:0] packBits(int base, bit lsb);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++)
      if (lsb) v[i] = bitQ[base+i]; else v[7-i] = bitQ[base+i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) expReg[i] = mDef[i];
      bitQ.delete(); prevSclk = 0; expSdo = 0; lsbTx = 0; instrV = 0; rdByte = 0;
    end else begin
      if (spiCsN) begin
        bitQ.delete(); expSdo = 0; instrV = 0; lsbTx = expReg[0][6];
      end else if (spiClk && !prevSclk && bitQ.size() < 16) begin
        bitQ.push_back(spiDin);
        if (bitQ.size() == 8) begin
          instrV = packBits(0, lsbTx);
          rdByte = (instrV[6:0] < 8) ? expReg[instrV[2:0]] : 8'h00;
        end
        if (bitQ.size() == 16 && !instrV[7]) begin
          logic [7:0] d;
          d = packBits(8, lsbTx);
          if (instrV[6:0] == 0 && d[5])
            for (int i = 0; i < 8; i++) expReg[i] = mDef[i];
          else if (instrV[6:0] < 8)
            expReg[instrV[2:0]] = d & mMask[instrV[2:0]];
        end
      end else if (!spiClk && prevSclk && bitQ.size() >= 8 && bitQ.size() < 16 && instrV[7]) begin
        int k;
        k = bitQ.size() - 8;
        expSdo = lsbTx ? rdByte[k] : rdByte[7-k];
      end
      prevSclk = spiClk;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 lsbFirst", lsbFirst, expReg[0][6]);
      chk("R5 interpClkStop", interpClkStop, expReg[0][4]);
      chk("R5 pdI", pdI, expReg[0][3]);
      chk("R5 pdQ", pdQ, expReg[0][2]);
      chk("R5 fullPowerDown", fullPowerDown, expReg[0][3] & expReg[0][2]);
      chk("R6 interpRatio", interpRatio, expReg[1][7:6]);
      chk("R6 firHighpass", firHighpass, expReg[1][5]);
      chk("R6 modFreq", modFreq, expReg[1][4:3]);
      chk("R6 modReal", modReal, expReg[1][2]);
      chk("R6 modSignInv", modSignInv, expReg[1][1]);
      chk("R7 offsetBinary", offsetBinary, expReg[2][7]);
      chk("R7 latchFalling", latchFalling, expReg[2][4]);
      chk("R8 fineGain", fineGain, expReg[4]);
      chk("R8 coarseGain", coarseGain, expReg[5][3:0]);
      chk("R9 offsetCode", offsetCode, {expReg[6], expReg[7][1:0]});
      chk("R10 spiDout", spiDout, expSdo);
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit rw, input logic [6:0] addr, input logic [7:0] data,
                      input bit lsb, input int nBits, output logic [7:0] rd);
    logic [7:0] ins;
    ins = {rw, addr};
    rd = '0;
    spiCsN = 1'b0;
    waitN(2);
    for (int i = 0; i < nBits; i++) begin
      int j;
      logic [7:0] b;
      j = i % 8;
      b = (i < 8) ? ins : data;
      spiClk = 1'b0;
      spiDin = lsb ? b[j] : b[7-j];
      waitN(2);
      if (i >= 8) begin
        if (lsb) rd[j] = spiDout; else rd[7-j] = spiDout;
      end
      spiClk = 1'b1;
      waitN(2);
    end
    spiClk = 1'b0;
    waitN(2);
    spiCsN = 1'b1;
    waitN(3);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input bit lsb);
    logic [7:0] r;
    xfer(1'b0, a, d, lsb, 16, r);
  endtask

  task automatic rd(input logic [6:0] a, input bit lsb, output logic [7:0] r);
    xfer(1'b1, a, 8'h00, lsb, 16, r);
  endtask

  initial begin
    logic [7:0] r;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // R1 defaults
    chk("R1 interpRatio", interpRatio, 2'b11);
    chk("R1 modFreq", modFreq, 2'b10);
    chk("R1 modReal", modReal, 1);
    chk("R1 coarseGain", coarseGain, 4'hF);
    chk("R1 lsbFirst", lsbFirst, 0);
    chk("R1 offsetCode", offsetCode, 0);

    wr(7'h04, 8'hA5, 0);
    chk("R2 R8 fineGain write", fineGain, 8'hA5);
    wr(7'h05, 8'h37, 0);
    chk("R8 R11 coarseGain", coarseGain, 4'h7);
    rd(7'h05, 0, r);
    chk("R10 R11 read reg5", r, 8'h07);
    wr(7'h06, 8'hFF, 0);
    wr(7'h07, 8'hFE, 0);
    chk("R9 offsetCode", offsetCode, 10'h3FE);
    wr(7'h01, 8'h2B, 0);
    chk("R6 interpRatio", interpRatio, 2'b00);
    chk("R6 firHighpass", firHighpass, 1);
    chk("R6 modFreq", modFreq, 2'b01);
    chk("R6 modReal", modReal, 0);
    chk("R6 modSignInv", modSignInv, 1);
    wr(7'h02, 8'hFF, 0);
    chk("R7 offsetBinary", offsetBinary, 1);
    chk("R7 latchFalling", latchFalling, 1);
    rd(7'h02, 0, r);
    chk("R10 R11 read reg2", r, 8'h90);
    wr(7'h00, 8'h0C, 0);
    chk("R5 fullPowerDown both", fullPowerDown, 1);
    wr(7'h00, 8'h18, 0);
    chk("R5 fullPowerDown one", fullPowerDown, 0);
    chk("R5 interpClkStop", interpClkStop, 1);
    rd(7'h00, 0, r);
    chk("R10 read reg0", r, 8'h18);
    wr(7'h20, 8'hFF, 0);
    rd(7'h20, 0, r);
    chk("R11 unmapped read", r, 8'h00);
    wr(7'h03, 8'hFF, 0);
    rd(7'h03, 0, r);
    chk("R11 unused reg3 read", r, 8'h00);
    xfer(1'b0, 7'h04, 8'h11, 0, 12, r);
    chk("R12 aborted write", fineGain, 8'hA5);
    // Bit order switch
    wr(7'h00, 8'h40, 0);
    chk("R3 lsbFirst set", lsbFirst, 1);
    wr(7'h04, 8'h3C, 1);
    chk("R3 lsb-first write", fineGain, 8'h3C);
    rd(7'h04, 1, r);
    chk("R3 R10 lsb-first read", r, 8'h3C);
    wr(7'h06, 8'h81, 1);
    chk("R3 R9 lsb-first offset", offsetCode, 10'h206);
    // Soft reset (sent in LSB-first order)
    wr(7'h00, 8'h20, 1);
    chk("R4 lsbFirst cleared", lsbFirst, 0);
    chk("R4 fineGain default", fineGain, 8'h00);
    chk("R4 interpRatio default", interpRatio, 2'b11);
    chk("R4 coarseGain default", coarseGain, 4'hF);
    rd(7'h00, 0, r);
    chk("R4 reset bit reads zero", r, 8'h00);
    rd(7'h01, 0, r);
    chk("R4 R10 reg1 default", r, 8'hD4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule